// File: doc/BRIEF.md
# PCI Configuration Access Bridge

The bridge turns host accesses that fall in a sparse configuration window into single configuration cycles on a plain internal bus-master port. The host address carries everything: the configuration address (bus, device, function, register offset) sits above bit 5, and a two-bit length code in bits 4:3 says whether the host wants a byte, a 16-bit word or a 32-bit doubleword. From these the bridge forms either a Type 0 cycle (local bus, one-hot device select) or a Type 1 cycle (forwarded through bridges). It also computes the byte enables and moves write data onto the correct byte lanes.

A small register port gives software a cycle-type control register and a sticky error status register. When the target ends a cycle with a master abort or a target abort, a read returns all ones and the matching status bit is set. A word access that would cross the doubleword boundary, or a reserved length code, counts as an illegal access. No bus cycle is started for it, a read returns all ones, and a status bit records it.

The controller is a three-state machine. IDLE accepts a request when `host_req` is high: it goes to REPLY for an illegal access and to BUS otherwise. BUS holds `cfg_req` until `cfg_done`, then goes to REPLY. REPLY pulses `host_ack` for one cycle and returns to IDLE.

Top module: `cfg_access_bridge`

## Requirements
- R1: The host address decodes as bus = [28:21], device = [20:16], function = [15:13], register offset = [12:5], length code = [4:3]. The codes are 00 byte, 01 word, 11 doubleword and 10 reserved. Bits 2:0 have no effect.
- R2: A Type 0 cycle drives cfg_addr = one-hot select bit (11 + device) for devices 0..20 (no select bit for devices 21..31), function in [10:8], offset[7:2] in [7:2], and [1:0] = 00.
- R3: A Type 1 cycle is used when the control register bits [1:0] equal 01. Any other value gives Type 0. A Type 1 cycle drives [31:24] = 0, bus in [23:16], device in [15:11], function in [10:8], offset[7:2] in [7:2], and [1:0] = 01.
- R4: Byte enables are 0001 << offset[1:0] for a byte, 0011 << offset[1:0] for a word at offset 0..2, and 1111 for a doubleword.
- R5: For byte and word writes, cfg_wdata = host_wdata shifted left by 8 × offset[1:0]. For doubleword writes it is host_wdata unshifted.
- R6: A read with no abort returns cfg_rdata to the host unshifted, as a full doubleword.
- R7: A master abort returns 0xFFFFFFFF on a read and sets status bit 0.
- R8: A target abort returns 0xFFFFFFFF on a read and sets status bit 1.
- R9: A word at offset 3, or length code 10, is illegal. It starts no bus cycle, is acknowledged with 0xFFFFFFFF read data, and sets status bit 2.
- R10: Status bits are sticky. Writing 1 to a bit (reg_sel = 1) clears it and writing 0 leaves it unchanged. A new error in the same cycle as a clear leaves the bit set.
- R11: host_ready is high only in IDLE. Each accepted request gets exactly one single-cycle host_ack. cfg_req stays high until cfg_done.
- R12: After reset the controller is in IDLE (host_ready = 1, host_ack = 0, cfg_req = 0), and the control and status registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host access request, taken when host_ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 29 | Sparse configuration address with length code |
| host_wdata | input | 32 | Host write data, right-aligned for byte and word |
| host_ready | output | 1 | Bridge idle, can accept a request |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, valid with host_ack |
| reg_we | input | 1 | Register port write strobe |
| reg_sel | input | 1 | 0 = cycle-type control, 1 = error status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value |
| cfg_req | output | 1 | Configuration cycle request |
| cfg_we | output | 1 | Cycle is a write |
| cfg_addr | output | 32 | Formed Type 0 or Type 1 address |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_done | input | 1 | Target completes the cycle |
| cfg_rdata | input | 32 | Target read data |
| cfg_mabort | input | 1 | Cycle ended by master abort |
| cfg_tabort | input | 1 | Cycle ended by target abort |

## Verification
The hardest case to reach is an abort that lands in the same clock edge as a software write-one-to-clear of that same status bit, because the two events come from different ports. The bench target model drives the clearing register write in the same cycle it raises cfg_done with a target abort, so the set-wins rule is observed directly. The rest of the stimulus is a sweep over length code, offset, direction, device number, target latency and control value, with every address, enable and data lane predicted arithmetically.

// File: rtl/cab_pkg.sv
package cab_pkg;
    localparam int DATA_W    = 32;
    localparam int BE_W      = DATA_W / 8;
    localparam int BUS_W     = 8;
    localparam int DEV_W     = 5;
    localparam int FUNC_W    = 3;
    localparam int REG_W     = 8;
    localparam int LEN_LSB   = 3;
    localparam int CFG_SHIFT = 5;
    localparam int CA_W      = BUS_W + DEV_W + FUNC_W + REG_W;
    localparam int HADDR_W   = CFG_SHIFT + CA_W;
    localparam int SEL_LSB   = FUNC_W + REG_W;
    localparam int NSEL      = DATA_W - SEL_LSB;
    localparam int ERR_W     = 3;
    localparam int ERR_MA    = 0;
    localparam int ERR_TA    = 1;
    localparam int ERR_ILL   = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUS   = 2'd1,
        ST_REPLY = 2'd2
    } cab_state_e;

    typedef enum logic [1:0] {
        LEN_BYTE  = 2'b00,
        LEN_WORD  = 2'b01,
        LEN_RSVD  = 2'b10,
        LEN_DWORD = 2'b11
    } cab_len_e;

    typedef struct packed {
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FUNC_W-1:0] func;
        logic [REG_W-1:0]  regno;
    } cab_cfgaddr_t;
endpackage

// File: rtl/cab_decode.sv
module cab_decode
    import cab_pkg::*;
(
    input  logic [HADDR_W-1:0] haddr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               type1,
    output logic [DATA_W-1:0]  bus_addr,
    output logic [BE_W-1:0]    be,
    output logic [DATA_W-1:0]  lane_wdata,
    output logic               illegal
);
    cab_cfgaddr_t     ca;
    cab_len_e         len;
    logic [1:0]       off;
    logic [NSEL-1:0]  idsel;
    logic [DATA_W-1:0] t0_addr;
    logic [DATA_W-1:0] t1_addr;

    assign ca  = cab_cfgaddr_t'(haddr[HADDR_W-1:CFG_SHIFT]);
    assign len = cab_len_e'(haddr[LEN_LSB+1:LEN_LSB]);
    assign off = ca.regno[1:0];

    for (genvar g = 0; g < NSEL; g++) begin : g_idsel
        assign idsel[g] = (ca.dev == DEV_W'(g));
    end

    assign t0_addr = {idsel, ca.func, ca.regno[REG_W-1:2], 2'b00};
    assign t1_addr = {{(DATA_W-CA_W){1'b0}}, ca.bus, ca.dev, ca.func,
                      ca.regno[REG_W-1:2], 2'b01};
    assign bus_addr = type1 ? t1_addr : t0_addr;

    always_comb begin
        be      = '0;
        illegal = 1'b0;
        unique case (len)
            LEN_BYTE:  be = BE_W'(4'b0001) << off;
            LEN_WORD: begin
                be      = BE_W'(4'b0011) << off;
                illegal = (off == 2'd3);
            end
            LEN_DWORD: be = '1;
            LEN_RSVD:  illegal = 1'b1;
        endcase
    end

    assign lane_wdata = (len == LEN_DWORD) ? wdata : (wdata << {off, 3'b000});
endmodule

// File: rtl/cab_status.sv
module cab_status
    import cab_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] set,
    input  logic             clr_we,
    input  logic [ERR_W-1:0] clr,
    output logic [ERR_W-1:0] flags
);
    logic [ERR_W-1:0] clr_eff;
    assign clr_eff = clr_we ? clr : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_eff) | set;
    end

    for (genvar g = 0; g < ERR_W; g++) begin : g_chk
        a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            flags[g] && !(clr_we && clr[g]) |=> flags[g]);
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[g] |=> flags[g]);
    end
endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
    import cab_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_req,
    input  logic                host_we,
    input  logic [HADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic                host_ready,
    output logic                host_ack,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic                reg_we,
    input  logic                reg_sel,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                cfg_req,
    output logic                cfg_we,
    output logic [DATA_W-1:0]   cfg_addr,
    output logic [BE_W-1:0]     cfg_be,
    output logic [DATA_W-1:0]   cfg_wdata,
    input  logic                cfg_done,
    input  logic [DATA_W-1:0]   cfg_rdata,
    input  logic                cfg_mabort,
    input  logic                cfg_tabort
);
    cab_state_e        state_q, state_d;
    logic [1:0]        ctrl_q;
    logic              type1;
    logic              type1_q;
    logic [DATA_W-1:0] dec_addr, dec_wdata;
    logic [BE_W-1:0]   dec_be;
    logic              dec_illegal;
    logic              accept;
    logic              bus_end;
    logic [DATA_W-1:0] addr_q, wdata_q, rdata_q;
    logic [BE_W-1:0]   be_q;
    logic              we_q;
    logic [ERR_W-1:0]  err_set, err_flags;

    assign type1 = (ctrl_q == 2'b01);

    cab_decode u_decode (
        .haddr      (host_addr),
        .wdata      (host_wdata),
        .type1      (type1),
        .bus_addr   (dec_addr),
        .be         (dec_be),
        .lane_wdata (dec_wdata),
        .illegal    (dec_illegal)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (host_req) state_d = dec_illegal ? ST_REPLY : ST_BUS;
            ST_BUS:   if (cfg_done) state_d = ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        host_ready = 1'b0;
        host_ack   = 1'b0;
        cfg_req    = 1'b0;
        unique case (state_q)
            ST_IDLE:  host_ready = 1'b1;
            ST_BUS:   cfg_req    = 1'b1;
            ST_REPLY: host_ack   = 1'b1;
            default:  ;
        endcase
    end

    assign accept  = host_ready && host_req;
    assign bus_end = cfg_req && cfg_done;

    // Request capture and response data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            we_q    <= 1'b0;
            type1_q <= 1'b0;
            rdata_q <= '0;
        end else if (accept) begin
            addr_q  <= dec_addr;
            wdata_q <= dec_wdata;
            be_q    <= dec_be;
            we_q    <= host_we;
            type1_q <= type1;
            if (dec_illegal) rdata_q <= '1;
        end else if (bus_end) begin
            rdata_q <= (cfg_mabort || cfg_tabort) ? '1 : cfg_rdata;
        end
    end

    assign cfg_addr   = addr_q;
    assign cfg_wdata  = wdata_q;
    assign cfg_be     = be_q;
    assign cfg_we     = we_q;
    assign host_rdata = rdata_q;

    // Control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  ctrl_q <= 2'b00;
        else if (reg_we && !reg_sel) ctrl_q <= reg_wdata[1:0];
    end

    always_comb begin
        err_set          = '0;
        err_set[ERR_MA]  = bus_end && cfg_mabort;
        err_set[ERR_TA]  = bus_end && cfg_tabort;
        err_set[ERR_ILL] = accept && dec_illegal;
    end

    cab_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (err_set),
        .clr_we (reg_we && reg_sel),
        .clr    (reg_wdata[ERR_W-1:0]),
        .flags  (err_flags)
    );

    assign reg_rdata = reg_sel ? DATA_W'(err_flags) : DATA_W'(ctrl_q);

    a_r11_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_done |=> cfg_req);
    a_r9_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        accept && dec_illegal |=> !cfg_req && host_ack && host_rdata == '1);
    a_r2_type0_form: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !type1_q |-> cfg_addr[1:0] == 2'b00 && $onehot0(cfg_addr[DATA_W-1:SEL_LSB]));
    a_r3_type1_form: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && type1_q |-> cfg_addr[1:0] == 2'b01 && cfg_addr[DATA_W-1:CA_W] == '0);
    a_r4_be_present: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> cfg_be != '0);
    a_r7_abort_ones: assert property (@(posedge clk) disable iff (!rst_n)
        bus_end && (cfg_mabort || cfg_tabort) |=> host_ack && host_rdata == '1);
endmodule

// File: tb/test_cfg_access_bridge.sv
module test_cfg_access_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [28:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready, host_ack;
    logic [31:0] host_rdata;
    logic        reg_we = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        cfg_req, cfg_we;
    logic [31:0] cfg_addr, cfg_wdata;
    logic [3:0]  cfg_be;
    logic        cfg_done = 1'b0, cfg_mabort = 1'b0, cfg_tabort = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int n_chk = 0, n_fail = 0;
    // target model state
    int          tgt_lat = 0, lat_cnt = 0, bus_count = 0;
    logic [31:0] tgt_data = '0;
    logic        tgt_ma = 1'b0, tgt_ta = 1'b0, clr_at_done = 1'b0, clr_pulse = 1'b0;
    logic [31:0] seen_addr, seen_wdata;
    logic [3:0]  seen_be;
    logic        seen_we;

    always #2 clk = ~clk;

    cfg_access_bridge i_cfg_access_bridge (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ready(host_ready), .host_ack(host_ack),
        .host_rdata(host_rdata),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_done(cfg_done), .cfg_rdata(cfg_rdata),
        .cfg_mabort(cfg_mabort), .cfg_tabort(cfg_tabort)
    );

    always @(negedge clk) begin
        if (clr_pulse) begin
            reg_we    = 1'b0;
            clr_pulse = 1'b0;
        end
        if (cfg_req && !cfg_done) begin
            if (lat_cnt >= tgt_lat) begin
                cfg_done   = 1'b1;
                cfg_rdata  = tgt_data;
                cfg_mabort = tgt_ma;
                cfg_tabort = tgt_ta;
                seen_addr  = cfg_addr;
                seen_be    = cfg_be;
                seen_wdata = cfg_wdata;
                seen_we    = cfg_we;
                bus_count++;
                lat_cnt = 0;
                if (clr_at_done) begin
                    reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = '1; clr_pulse = 1'b1;
                end
            end else begin
                lat_cnt++;
            end
        end else begin
            cfg_done = 1'b0; cfg_mabort = 1'b0; cfg_tabort = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic sel, output logic [31:0] v);
        @(negedge clk);
        reg_sel = sel;
        #0.5 v = reg_rdata;
    endtask

    // One host access; returns read data and bus cycles consumed
    task automatic host_access(input logic we, input logic [23:0] ca, input logic [1:0] lc,
                               input logic [31:0] wd, output logic [31:0] rd, output int nbus);
        int b0;
        int waitc;
        b0 = bus_count;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_wdata = wd;
        host_addr = {ca, lc, 3'b101};
        @(negedge clk);
        host_req = 1'b0;
        waitc = 0;
        while (!host_ack && waitc < 50) begin
            if (waitc == 0) chk(!host_ready, "R11 ready low while busy", {31'b0, host_ready}, 32'h0);
            @(negedge clk);
            waitc++;
        end
        chk(host_ack, "R11 ack arrives", {31'b0, host_ack}, 32'h1);
        rd = host_rdata;
        nbus = bus_count - b0;
        @(negedge clk);
        chk(!host_ack, "R11 ack single cycle", {31'b0, host_ack}, 32'h0);
    endtask

    logic [31:0] v, rd, ea, ebe, ewd;
    int nb;

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(host_ready && !host_ack && !cfg_req, "R12 idle after reset",
            {29'b0, host_ready, host_ack, cfg_req}, 32'h4);
        reg_read(1'b0, v); chk(v == 0, "R12 control reset", v, 0);
        reg_read(1'b1, v); chk(v == 0, "R12 status reset", v, 0);

        // Sweep: control value, length code, offset, direction, device
        for (int cv = 0; cv < 4; cv++) begin
            reg_write(1'b0, 32'(cv));
            for (int lc = 0; lc < 4; lc++)
            for (int off = 0; off < 4; off++)
            for (int we = 0; we < 2; we++)
            for (int di = 0; di < 4; di++) begin
                logic [7:0]  bus, regno;
                logic [4:0]  dev;
                logic [2:0]  func;
                logic [31:0] wd;
                bit          ill;
                dev   = (di == 0) ? 5'd0 : (di == 1) ? 5'd7 : (di == 2) ? 5'd20 : 5'd27;
                bus   = 8'(8'h3C + cv * 17 + di);
                func  = 3'(lc + off + di);
                regno = {6'(6'h15 + lc * 5 + di), 2'(off)};
                wd    = 32'h000000A5 | (32'(lc) << 8) | (32'(di) << 12) | 32'hC3000000;
                tgt_data = 32'h1234_5600 | 32'(cv * 64 + lc * 16 + off * 4 + di);
                tgt_lat  = off;
                ill = (lc == 2) || (lc == 1 && off == 3);
                host_access(1'(we), {bus, dev, func, regno}, 2'(lc), wd, rd, nb);
                if (ill) begin
                    chk(nb == 0, "R9 no bus cycle for illegal", 32'(nb), 0);
                    chk(rd == 32'hFFFF_FFFF, "R9 illegal reads ones", rd, 32'hFFFF_FFFF);
                    reg_read(1'b1, v);
                    chk(v == 32'h4, "R9 illegal status bit", v, 32'h4);
                    reg_write(1'b1, 32'h4);
                end else begin
                    chk(nb == 1, "R11 one bus cycle", 32'(nb), 1);
                    if (cv == 1)
                        ea = {8'h00, bus, dev, func, regno[7:2], 2'b01};
                    else
                        ea = ((dev < 21) ? (32'h1 << (11 + dev)) : 32'h0) |
                             (32'(func) << 8) | (32'(regno[7:2]) << 2);
                    chk(seen_addr == ea, (cv == 1) ? "R3 type1 address" : "R2 type0 address",
                        seen_addr, ea);
                    chk(seen_we == 1'(we), "R1 direction", {31'b0, seen_we}, 32'(we));
                    ebe = (lc == 0) ? (32'h1 << off) : (lc == 1) ? (32'h3 << off) : 32'hF;
                    chk({28'b0, seen_be} == ebe, "R4 byte enables", {28'b0, seen_be}, ebe);
                    if (we == 1) begin
                        ewd = (lc == 3) ? wd : (wd << (8 * off));
                        chk(seen_wdata == ewd, "R5 write lanes", seen_wdata, ewd);
                    end else begin
                        chk(rd == tgt_data, "R6 read unshifted", rd, tgt_data);
                    end
                end
            end
        end
        reg_write(1'b0, 32'h0);
        tgt_lat = 1;
        reg_read(1'b0, v); chk(v == 0, "R3 control writable", v, 0);

        // R7 master abort on read
        tgt_ma = 1'b1; tgt_data = 32'h0BAD_0BAD;
        host_access(1'b0, 24'h01_0810, 2'b11, 32'h0, rd, nb);
        chk(rd == 32'hFFFF_FFFF, "R7 master abort reads ones", rd, 32'hFFFF_FFFF);
        tgt_ma = 1'b0;
        reg_read(1'b1, v); chk(v == 32'h1, "R7 master abort status", v, 32'h1);
        // later good read still works, bit stays (R10)
        host_access(1'b0, 24'h00_0004, 2'b11, 32'h0, rd, nb);
        chk(rd == 32'h0BAD_0BAD, "R6 read after abort", rd, 32'h0BAD_0BAD);
        reg_read(1'b1, v); chk(v == 32'h1, "R10 status sticky", v, 32'h1);

        // R8 target abort on read and on write
        tgt_ta = 1'b1;
        host_access(1'b0, 24'h02_1120, 2'b00, 32'h0, rd, nb);
        chk(rd == 32'hFFFF_FFFF, "R8 target abort reads ones", rd, 32'hFFFF_FFFF);
        host_access(1'b1, 24'h02_1124, 2'b11, 32'h5A5A_5A5A, rd, nb);
        tgt_ta = 1'b0;
        reg_read(1'b1, v); chk(v == 32'h3, "R8 target abort status", v, 32'h3);

        // R10 write-one-to-clear selective, zeros ignored
        reg_write(1'b1, 32'h0);
        reg_read(1'b1, v); chk(v == 32'h3, "R10 zero write no effect", v, 32'h3);
        reg_write(1'b1, 32'h1);
        reg_read(1'b1, v); chk(v == 32'h2, "R10 clear one bit", v, 32'h2);
        reg_write(1'b1, v);
        reg_read(1'b1, v); chk(v == 32'h0, "R10 write back clears", v, 32'h0);
        reg_read(1'b0, v); chk(v == 32'h0, "R10 status write leaves control", v, 0);

        // R10 set and clear in the same cycle: set wins
        tgt_ta = 1'b1; clr_at_done = 1'b1;
        host_access(1'b0, 24'h00_0008, 2'b11, 32'h0, rd, nb);
        tgt_ta = 1'b0; clr_at_done = 1'b0;
        reg_read(1'b1, v); chk(v == 32'h2, "R10 set wins over clear", v, 32'h2);
        reg_write(1'b1, 32'h7);
        reg_read(1'b1, v); chk(v == 32'h0, "R10 final clear", v, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule